// File: doc/BRIEF.md
# Soft Mute Ramp and Zero Detect

This block sits in the audio datapath between the serial-port receiver and the interpolation filter. It multiplies each stereo sample pair by a digital gain. The gain is held as an attenuation index from 0 to 104. Each index is one decibel of attenuation, and index 104 means the output is exactly zero. On each accepted sample the index moves by one step toward the end that the control inputs request. Muting and un-muting therefore fade over 104 sample periods and never jump.

Three sources can request a fade to silence: the soft-mute control, a fault input driven by the clock monitor or by the first undervoltage threshold, and a hard undervoltage input for the second threshold. While the fault input is high, the block replaces the incoming data with the last pair it accepted while the fault was low. Only that known-good pair is faded out. A single analog-mute request output combines three conditions: the fade has reached silence, a long run of all-zero frames has been seen, or the hard undervoltage input is high.

The attenuation coefficients are built into the block and computed when it is elaborated. The analog mute circuitry itself lies outside this block.

Top module: `soft_mute_gain`

## Requirements
- R1: While reset is held, `out_valid` is 0, both output samples are 0 and `amute_o` is 1. Reset puts the attenuation index at 104 (silent).
- R2: `out_valid` rises one clock after `in_valid` and the output pair is updated on that same edge. Each output is floor(x*c/32768), where c = round(32768*10^(-k/20)) for index k below 104, c = 0 at k = 104, and k is the index before that sample's step. At k = 0 every input value, including both full-scale extremes, passes unchanged.
- R3: While a mute is requested (`mute_n` low, `fault_req` high or `uv_hard` high), each accepted sample raises the index by 1. The index stays at 104 once it is there, so a fade from 0 dB needs 104 samples and the 105th output is 0.
- R4: With no mute requested, each accepted sample lowers the index by 1, down to 0, so a fade in from silence takes 104 samples.
- R5: A change of request in the middle of a fade reverses the direction from the current index. The first sample after the change uses that index unchanged.
- R6: The fade path requests analog mute on the edge where the index reaches 104 while a mute is requested. It drops the request on the first clock edge after the mute request goes away.
- R7: After 1024 consecutive accepted frames in which both channels are zero, `amute_o` is asserted on the edge of the 1024th frame, not earlier. It stays asserted while zero frames continue.
- R8: An accepted frame with either channel non-zero clears the zero-run count and withdraws the zero-run analog mute on that frame's edge.
- R9: While `fault_req` is high, the pair that is scaled, and that feeds zero detection, is the last pair accepted while `fault_req` was low. The fault also requests a mute, as in R3.
- R10: `uv_hard` high asserts `amute_o` on the next clock edge whatever the index and data, and also requests a mute. Its contribution is removed one edge after it falls.
- R11: Clocks without `in_valid` change neither the index nor the output samples, and they keep `out_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe marking a new stereo pair |
| in_left | input | SAMPLE_W | Left sample, signed two's complement |
| in_right | input | SAMPLE_W | Right sample, signed two's complement |
| mute_n | input | 1 | Soft-mute control: 0 fades out, 1 fades in |
| fault_req | input | 1 | Clock error or first undervoltage threshold: fade out the last good pair |
| uv_hard | input | 1 | Second undervoltage threshold: force analog mute at once |
| out_valid | output | 1 | Strobe marking an updated output pair |
| out_left | output | SAMPLE_W | Scaled left sample |
| out_right | output | SAMPLE_W | Scaled right sample |
| amute_o | output | 1 | Analog-mute request |

## Verification
The hardest states to reach from the ports are the edges of the two long counters. One is the 1023rd versus the 1024th zero frame. The other is a fade reversed at an index between its ends. The bench reaches these by driving exact frame counts. It keeps its own count of the expected index and zero run, so every single frame is compared against a model built from the requirements.

The held-pair substitution needs its own sequence. A distinctive pair is accepted first, the fault is raised, and clearly different data is then streamed in. Any output that follows the live input instead of the held pair shows up as a mismatch.

// File: rtl/smute_pkg.sv
// Shared constants and the coefficient generator for the soft mute block.
// Assumes coefficients are unsigned with COEF_FRAC fractional bits, so that
// unity gain (1 << COEF_FRAC) fits in COEF_W bits.
package smute_pkg;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 15;

    // Linear gain for an attenuation of k dB, rounded; silent at or past steps.
    function automatic logic [COEF_W-1:0] db_coef(input int k, input int steps);
        real g;
        if (k >= steps) return '0;
        g = real'(1 << COEF_FRAC) * (10.0 ** (-real'(k) / 20.0));
        return COEF_W'($rtoi(g + 0.5));
    endfunction
endpackage

// File: rtl/smute_gain_rom.sv
// Attenuation-index to linear-coefficient lookup, filled at elaboration.
// Assumes idx never exceeds STEPS; any larger index reads as silence.
module smute_gain_rom #(
    parameter int STEPS = 104,
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0]               idx,
    output logic [smute_pkg::COEF_W-1:0]   coef
);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(STEPS);

    logic [smute_pkg::COEF_W-1:0] table_q [0:STEPS];

    for (genvar g = 0; g <= STEPS; g++) begin : g_entry
        assign table_q[g] = smute_pkg::db_coef(g, STEPS);
    end

    // Select the coefficient for the current index, silence when out of range.
    always_comb begin
        coef = '0;
        if (idx <= IDX_MAX) coef = table_q[idx];
    end
endmodule

// File: rtl/smute_ramp.sv
// Attenuation index stepper: one dB per accepted sample toward the requested
// end, plus the analog-mute request of the fade path.
// Assumes step_en is a single-cycle strobe per stereo frame.
module smute_ramp #(
    parameter int STEPS = 104,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             want_mute,
    output logic [IDX_W-1:0] idx,
    output logic             ramp_mute
);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(STEPS);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    logic [IDX_W-1:0] idx_nxt;

    // Next index: one step toward silence or toward full gain on each sample.
    always_comb begin
        idx_nxt = idx;
        if (step_en) begin
            if (want_mute) begin
                if (idx != IDX_MAX) idx_nxt = idx + IDX_ONE;
            end else if (idx != '0) begin
                idx_nxt = idx - IDX_ONE;
            end
        end
    end

    // Index and fade-path mute flag registers; reset starts silent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= IDX_MAX;
            ramp_mute <= 1'b1;
        end else begin
            idx       <= idx_nxt;
            ramp_mute <= want_mute && (idx_nxt == IDX_MAX);
        end
    end

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_MAX);
    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && want_mute && (idx != IDX_MAX) |=> idx == $past(idx) + IDX_ONE);
    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en && !want_mute && (idx != '0) |=> idx == $past(idx) - IDX_ONE);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(idx));
    // R6
    ramp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_mute |-> idx == IDX_MAX);
    // R6
    ramp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !want_mute |=> !ramp_mute);
endmodule

// File: rtl/smute_zero_watch.sv
// Counts consecutive all-zero frames and flags a long silent run.
// Assumes frame_en marks each frame once; the count saturates at RUN_LEN.
module smute_zero_watch #(
    parameter int RUN_LEN = 1024,
    parameter int CNT_W   = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_en,
    input  logic frame_zero,
    output logic zero_mute
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] run_q;

    // Zero-run counter: cleared by any non-zero frame, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (frame_en) begin
            if (!frame_zero)          run_q <= '0;
            else if (run_q != CNT_MAX) run_q <= run_q + CNT_ONE;
        end
    end

    assign zero_mute = (run_q == CNT_MAX);

    // R8
    zero_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_en && !frame_zero |=> !zero_mute);
    // R7
    zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_en && frame_zero && zero_mute |=> zero_mute);
    // R7
    zero_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_mute) |-> $past(frame_en && frame_zero));
endmodule

// File: rtl/smute_scaler.sv
// One channel of gain multiplication with a registered output.
// Assumes coef is at most unity, so the scaled result fits SAMPLE_W bits.
module smute_scaler #(
    parameter int SAMPLE_W = 24
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               en,
    input  logic signed [SAMPLE_W-1:0]         sample,
    input  logic [smute_pkg::COEF_W-1:0]       coef,
    output logic signed [SAMPLE_W-1:0]         out_q
);
    localparam int PROD_W = SAMPLE_W + smute_pkg::COEF_W + 1;
    localparam logic [smute_pkg::COEF_W-1:0] UNITY =
        smute_pkg::COEF_W'(1 << smute_pkg::COEF_FRAC);

    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] c_ext;
    logic signed [PROD_W-1:0] prod;

    // Signed product of sample and non-negative coefficient.
    always_comb begin
        s_ext = PROD_W'(sample);
        c_ext = PROD_W'($signed({1'b0, coef}));
        prod  = s_ext * c_ext;
    end

    // Register the rescaled product on each accepted sample, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  out_q <= '0;
        else if (en) out_q <= SAMPLE_W'(prod >>> smute_pkg::COEF_FRAC);
    end

    // R2
    silent_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && (coef == '0) |=> out_q == '0);
    // R2
    unity_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && (coef == UNITY) |=> out_q == $past(sample));
    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(out_q));
endmodule

// File: rtl/soft_mute_gain.sv
// Stereo soft mute with one-dB fade steps, held-sample fade on faults,
// zero-run detection and a combined analog-mute request.
// Assumes all inputs are synchronous to clk and in_valid is a one-cycle strobe.
module soft_mute_gain #(
    parameter int SAMPLE_W = 24,
    parameter int STEPS    = 104,
    parameter int ZERO_RUN = 1024
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic signed [SAMPLE_W-1:0]  in_left,
    input  logic signed [SAMPLE_W-1:0]  in_right,
    input  logic                        mute_n,
    input  logic                        fault_req,
    input  logic                        uv_hard,
    output logic                        out_valid,
    output logic signed [SAMPLE_W-1:0]  out_left,
    output logic signed [SAMPLE_W-1:0]  out_right,
    output logic                        amute_o
);
    localparam int IDX_W = $clog2(STEPS + 1);
    localparam int CNT_W = $clog2(ZERO_RUN + 1);
    localparam int NCH   = 2;

    logic                              want_mute;
    logic [IDX_W-1:0]                  idx;
    logic                              ramp_mute;
    logic                              zero_mute;
    logic                              uv_q;
    logic                              valid_q;
    logic                              frame_zero;
    logic [smute_pkg::COEF_W-1:0]      coef;
    logic signed [SAMPLE_W-1:0]        hold_s [NCH];
    logic signed [SAMPLE_W-1:0]        live_s [NCH];
    logic signed [SAMPLE_W-1:0]        sel_s  [NCH];
    logic signed [SAMPLE_W-1:0]        scaled [NCH];

    assign want_mute = !mute_n || fault_req || uv_hard;
    assign live_s[0] = in_left;
    assign live_s[1] = in_right;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Keep the last pair accepted while no fault is signalled.
        always_ff @(posedge clk) begin
            if (!rst_n)                     hold_s[c] <= '0;
            else if (in_valid && !fault_req) hold_s[c] <= live_s[c];
        end

        assign sel_s[c] = fault_req ? hold_s[c] : live_s[c];

        smute_scaler #(.SAMPLE_W(SAMPLE_W)) u_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (in_valid),
            .sample (sel_s[c]),
            .coef   (coef),
            .out_q  (scaled[c])
        );

        // R9
        hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fault_req |=> $stable(hold_s[c]));
    end

    assign frame_zero = (sel_s[0] == '0) && (sel_s[1] == '0);

    smute_gain_rom #(.STEPS(STEPS), .IDX_W(IDX_W)) u_rom (
        .idx  (idx),
        .coef (coef)
    );

    smute_ramp #(.STEPS(STEPS), .IDX_W(IDX_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (in_valid),
        .want_mute (want_mute),
        .idx       (idx),
        .ramp_mute (ramp_mute)
    );

    smute_zero_watch #(.RUN_LEN(ZERO_RUN), .CNT_W(CNT_W)) u_zero (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_en   (in_valid),
        .frame_zero (frame_zero),
        .zero_mute  (zero_mute)
    );

    // Output strobe and registered hard-undervoltage request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            uv_q    <= 1'b0;
        end else begin
            valid_q <= in_valid;
            uv_q    <= uv_hard;
        end
    end

    assign out_valid = valid_q;
    assign out_left  = scaled[0];
    assign out_right = scaled[1];
    assign amute_o   = zero_mute || ramp_mute || uv_q;

    // R10
    uv_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_hard |=> amute_o);
    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: tb/soft_mute_gain_bench.sv
`timescale 1ns/1ps
module soft_mute_gain_bench;
    localparam int SW    = 24;
    localparam int STEPS = 104;
    localparam int ZRUN  = 1024;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [SW-1:0] in_left = '0;
    logic signed [SW-1:0] in_right = '0;
    logic                 mute_n = 1'b0;
    logic                 fault_req = 1'b0;
    logic                 uv_hard = 1'b0;
    logic                 out_valid;
    logic signed [SW-1:0] out_left;
    logic signed [SW-1:0] out_right;
    logic                 amute_o;

    int n_chk = 0;
    int n_bad = 0;

    // reference model state, built from the requirements
    int     m_idx = STEPS;
    bit     m_ramp = 1'b1;
    bit     m_uvq = 1'b0;
    int     m_zc = 0;
    longint m_hl = 0;
    longint m_hr = 0;

    always #10 clk = ~clk;

    soft_mute_gain #(.SAMPLE_W(SW), .STEPS(STEPS), .ZERO_RUN(ZRUN)) u_soft_mute_gain (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .mute_n(mute_n), .fault_req(fault_req), .uv_hard(uv_hard),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .amute_o(amute_o)
    );

    function automatic longint coef_ref(input int k);
        if (k >= STEPS) return 0;
        return longint'($rtoi(32768.0 * (10.0 ** (-real'(k) / 20.0)) + 0.5));
    endfunction

    function automatic longint scale_ref(input longint x, input int k);
        longint p;
        p = x * coef_ref(k);
        return p >>> 15;
    endfunction

    function automatic bit exp_amute();
        return (m_zc >= ZRUN) || m_ramp || m_uvq;
    endfunction

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // change control inputs, let one edge pass, compare the mute request
    task automatic set_ctrl(input bit m, input bit f, input bit u, input string req);
        bit want;
        mute_n = m; fault_req = f; uv_hard = u;
        want = !m || f || u;
        m_ramp = want && (m_idx == STEPS);
        m_uvq = u;
        @(negedge clk);
        check_eq(req, "amute_o after control change", longint'(amute_o), longint'(exp_amute()));
    endtask

    // one accepted frame, checked against the model
    task automatic send_frame(input longint l, input longint r, input string req);
        bit want;
        longint sl, sr, el, er;
        int nidx;
        want = !mute_n || fault_req || uv_hard;
        sl = fault_req ? m_hl : l;
        sr = fault_req ? m_hr : r;
        el = scale_ref(sl, m_idx);
        er = scale_ref(sr, m_idx);
        nidx = m_idx;
        if (want && m_idx < STEPS) nidx = m_idx + 1;
        if (!want && m_idx > 0)    nidx = m_idx - 1;
        if (!fault_req) begin m_hl = l; m_hr = r; end
        if (sl == 0 && sr == 0) begin
            if (m_zc < ZRUN) m_zc++;
        end else m_zc = 0;
        m_idx = nidx;
        m_ramp = want && (nidx == STEPS);
        m_uvq = uv_hard;
        in_valid = 1'b1; in_left = SW'(l); in_right = SW'(r);
        @(negedge clk);
        in_valid = 1'b0;
        check_eq(req, "out_valid", longint'(out_valid), 1);
        check_eq(req, "out_left", longint'(out_left), el);
        check_eq(req, "out_right", longint'(out_right), er);
        check_eq(req, "amute_o", longint'(amute_o), longint'(exp_amute()));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_eq("R1", "out_valid in reset", longint'(out_valid), 0);
        check_eq("R1", "out_left in reset", longint'(out_left), 0);
        check_eq("R1", "out_right in reset", longint'(out_right), 0);
        check_eq("R1", "amute_o in reset", longint'(amute_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "amute_o after reset", longint'(amute_o), 1);
    endtask

    task automatic t_unmute();
        set_ctrl(1'b1, 1'b0, 1'b0, "R6");
        check_eq("R6", "release on un-mute request", longint'(amute_o), 0);
        for (int i = 0; i < STEPS; i++)
            send_frame(5000000 - i * 37011, -3000001 + i * 12345, "R4");
        send_frame(8388607, -8388608, "R2");
        check_eq("R2", "full-scale positive passthrough", longint'(out_left), 8388607);
        check_eq("R2", "full-scale negative passthrough", longint'(out_right), -8388608);
        send_frame(-1, 1, "R2");
    endtask

    task automatic t_mute();
        set_ctrl(1'b0, 1'b0, 1'b0, "R3");
        for (int i = 0; i < STEPS - 1; i++)
            send_frame(7000000 - i * 5000, -6000000 + i * 777, "R3");
        check_eq("R6", "no analog mute at index 103", longint'(amute_o), 0);
        send_frame(1234567, -1234567, "R3");
        check_eq("R6", "analog mute at index 104", longint'(amute_o), 1);
        send_frame(8388607, -8388608, "R3");
        check_eq("R3", "silent output after 104 steps", longint'(out_left), 0);
        send_frame(4000000, 4000000, "R3");
    endtask

    task automatic t_reverse();
        longint e40, e39;
        set_ctrl(1'b1, 1'b0, 1'b0, "R4");
        for (int i = 0; i < STEPS; i++) send_frame(3000000 + i, -3000000 - i, "R4");
        set_ctrl(1'b0, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 40; i++) send_frame(6543210, -6543210, "R5");
        set_ctrl(1'b1, 1'b0, 1'b0, "R5");
        e40 = scale_ref(6543210, 40);
        e39 = scale_ref(6543210, 39);
        send_frame(6543210, -6543210, "R5");
        check_eq("R5", "first sample after reversal", longint'(out_left), e40);
        send_frame(6543210, -6543210, "R5");
        check_eq("R5", "second sample after reversal", longint'(out_left), e39);
        for (int i = 0; i < 38; i++) send_frame(100000 + i, 200000 + i, "R5");
    endtask

    task automatic t_idle();
        longint hl, hr;
        hl = longint'(out_left);
        hr = longint'(out_right);
        for (int i = 0; i < 5; i++) begin
            in_left = SW'(11111 * (i + 1)); in_right = SW'(-22222 * (i + 1));
            @(negedge clk);
            check_eq("R11", "out_valid idle", longint'(out_valid), 0);
            check_eq("R11", "out_left held", longint'(out_left), hl);
            check_eq("R11", "out_right held", longint'(out_right), hr);
        end
        send_frame(2500000, -2500000, "R11");
    endtask

    task automatic t_zero();
        for (int i = 0; i < ZRUN - 1; i++) send_frame(0, 0, "R7");
        check_eq("R7", "no mute after 1023 zero frames", longint'(amute_o), 0);
        send_frame(0, 0, "R7");
        check_eq("R7", "mute after 1024 zero frames", longint'(amute_o), 1);
        for (int i = 0; i < 5; i++) send_frame(0, 0, "R7");
        check_eq("R7", "mute kept during zero run", longint'(amute_o), 1);
        send_frame(0, 5, "R8");
        check_eq("R8", "release on non-zero right channel", longint'(amute_o), 0);
        for (int i = 0; i < 10; i++) send_frame(0, 0, "R8");
        check_eq("R8", "count restarted from zero", longint'(amute_o), 0);
        send_frame(-3, 0, "R8");
    endtask

    task automatic t_fault();
        send_frame(123456, -654321, "R9");
        set_ctrl(1'b1, 1'b1, 1'b0, "R9");
        send_frame(7, 7, "R9");
        check_eq("R9", "held left pair at index 0", longint'(out_left), 123456);
        check_eq("R9", "held right pair at index 0", longint'(out_right), -654321);
        for (int i = 0; i < STEPS - 1; i++) send_frame(-8000000 + i, 0, "R9");
        check_eq("R9", "analog mute after fault fade", longint'(amute_o), 1);
        set_ctrl(1'b1, 1'b0, 1'b0, "R9");
        check_eq("R9", "release when fault clears", longint'(amute_o), 0);
        for (int i = 0; i < STEPS; i++) send_frame(42 + i, -42 - i, "R4");
    endtask

    task automatic t_uv();
        set_ctrl(1'b1, 1'b0, 1'b1, "R10");
        check_eq("R10", "hard undervoltage mute at full gain", longint'(amute_o), 1);
        for (int i = 0; i < 3; i++) send_frame(5555555, -5555555, "R10");
        set_ctrl(1'b1, 1'b0, 1'b0, "R10");
        check_eq("R10", "hard undervoltage released", longint'(amute_o), 0);
        for (int i = 0; i < 3; i++) send_frame(5555555, -5555555, "R10");
    endtask

    initial begin
        #(150000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_unmute();
        t_mute();
        t_reverse();
        t_idle();
        t_zero();
        t_fault();
        t_uv();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule